// File: doc/BRIEF.md
# Interrupt Status and Gating Unit with Toggle-on-Write

This block gathers the interrupt sources of a FIFO-based serial port into one status register, masks that register with a per-source enable register and a single master enable, and drives one level-sensitive interrupt line. The datapath feeds it two kinds of inputs. Level inputs report FIFO conditions that hold over many cycles: receive data present and receive FIFO full. Single-cycle pulses report events: a byte completing its transfer, receive overrun, transmit underrun and the transmit FIFO reaching half empty.

Software reaches the three registers through a 32-bit word-addressed write/read port. A write to the status register XORs the written word into the implemented bits. Writing a one to a set bit clears it, and writing a one to a clear bit sets it. Level conditions are ORed into the status on every clock, so a bit cleared while its condition still holds is set again at once. The interrupt output is registered and follows its cause by one clock.

Top module: `irq_agg`

## Requirements
- R1: After reset, the status, enable and master-enable registers read zero and `irq_o` is low.
- R2: Status and enable share one bit map: bit 2 = transfer completed (transmit data empty), bit 3 = transmit underrun, bit 4 = receive FIFO full, bit 5 = receive overrun, bit 6 = transmit FIFO half empty, bit 8 = receive data present. All other status and enable bits read 0.
- R3: Address 0 selects the status register. A write there sets each implemented bit to old value XOR written bit, so a one written to a clear bit sets that bit.
- R4: While `rx_nonempty_i` is high, status bit 8 is set on every clock. While `rx_full_i` is high, status bit 4 is set on every clock. A toggle write that tries to clear either bit while its input is high leaves the bit set.
- R5: A pulse on `xfer_done_i` sets status bits 2 and 8.
- R6: A pulse on `rx_overrun_i` sets bit 5, on `tx_underrun_i` sets bit 3, and on `tx_half_i` sets bit 6.
- R7: When a source sets a status bit in the same cycle as a write that toggles that bit, the bit ends up set.
- R8: `irq_o` is high in a cycle exactly when, in the previous cycle, status AND enable was nonzero and the master enable was set.
- R9: Address 1 selects the enable register, and only its R2 bits are stored. Address 2 selects the master-enable register, and only its bit 31 is stored. Address 3 reads zero, and writes to it have no effect.
- R10: Status bits outside the R2 map stay zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rx_nonempty_i | input | 1 | Level: receive FIFO holds data |
| rx_full_i | input | 1 | Level: receive FIFO full |
| rx_overrun_i | input | 1 | Pulse: a received byte was dropped |
| tx_underrun_i | input | 1 | Pulse: transmit ran out of data |
| tx_half_i | input | 1 | Pulse: transmit FIFO reached half empty |
| xfer_done_i | input | 1 | Pulse: a byte finished its transfer |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions take for granted that the datapath inputs are known values after reset and that `reg_wr` is a single-cycle strobe with stable address and data. The toggle-write property assumes that no source sets a bit in that cycle. The stimulus drives all inputs on the falling edge, keeps each event input high for exactly one cycle, and holds the level inputs low except in the scenarios that test them. Every toggle check is made in a cycle free of events, except the collision scenario, which exercises the event-wins rule on purpose.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] A_STAT = 2'd0,
  parameter logic [ADDR_W-1:0] A_EN   = 2'd1,
  parameter logic [ADDR_W-1:0] A_GIE  = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_nonempty_i,
  input  logic              rx_full_i,
  input  logic              rx_overrun_i,
  input  logic              tx_underrun_i,
  input  logic              tx_half_i,
  input  logic              xfer_done_i,
  output logic              irq_o
);
  localparam int B_TXE  = 2;
  localparam int B_TXU  = 3;
  localparam int B_RXF  = 4;
  localparam int B_RXO  = 5;
  localparam int B_TXH  = 6;
  localparam int B_RXNE = 8;
  localparam int B_GIE  = DATA_W - 1;
  localparam logic [DATA_W-1:0] SRC_MASK =
    (DATA_W'(1) << B_TXE) | (DATA_W'(1) << B_TXU) | (DATA_W'(1) << B_RXF) |
    (DATA_W'(1) << B_RXO) | (DATA_W'(1) << B_TXH) | (DATA_W'(1) << B_RXNE);

  logic [DATA_W-1:0] stat_q, en_q, set_vec, flip_vec;
  logic              gie_q;

  wire wr_stat = reg_wr && (reg_addr == A_STAT);
  wire wr_en   = reg_wr && (reg_addr == A_EN);
  wire wr_gie  = reg_wr && (reg_addr == A_GIE);

  always_comb begin
    set_vec         = '0;
    set_vec[B_TXE]  = xfer_done_i;
    set_vec[B_TXU]  = tx_underrun_i;
    set_vec[B_RXF]  = rx_full_i;
    set_vec[B_RXO]  = rx_overrun_i;
    set_vec[B_TXH]  = tx_half_i;
    set_vec[B_RXNE] = xfer_done_i | rx_nonempty_i;
  end

  assign flip_vec = wr_stat ? (reg_wdata & SRC_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= (stat_q ^ flip_vec) | set_vec;
      if (wr_en)  en_q  <= reg_wdata & SRC_MASK;
      if (wr_gie) gie_q <= reg_wdata[B_GIE];
      irq_o  <= gie_q && |(stat_q & en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT)     reg_rdata = stat_q;
    else if (reg_addr == A_EN)  reg_rdata = en_q;
    else if (reg_addr == A_GIE) reg_rdata[B_GIE] = gie_q;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              rx_nonempty_i,
  input logic              rx_full_i,
  input logic              rx_overrun_i,
  input logic              tx_underrun_i,
  input logic              tx_half_i,
  input logic              xfer_done_i,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              gie_q,
  input logic              irq_o
);
  localparam logic [DATA_W-1:0] MAP = DATA_W'(32'h0000_017C);
  wire quiet = !(rx_nonempty_i || rx_full_i || rx_overrun_i ||
                 tx_underrun_i || tx_half_i || xfer_done_i);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_q == '0 && en_q == '0 && !gie_q && !irq_o));
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && quiet) |=> stat_q == $past(stat_q ^ (reg_wdata & MAP)));
  a_r4_level_rxne: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nonempty_i |=> stat_q[8]);
  a_r4_level_rxf: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_i |=> stat_q[4]);
  a_r5_xfer_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> (stat_q[2] && stat_q[8]));
  a_r6_events: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun_i || tx_underrun_i || tx_half_i) |=>
      ((stat_q[5] || !$past(rx_overrun_i)) && (stat_q[3] || !$past(tx_underrun_i)) &&
       (stat_q[6] || !$past(tx_half_i))));
  a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq_o);
  a_r8_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |=> !irq_o);
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~MAP) == '0 && (en_q & ~MAP) == '0);
endmodule

bind irq_agg irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .rx_nonempty_i(rx_nonempty_i), .rx_full_i(rx_full_i),
  .rx_overrun_i(rx_overrun_i), .tx_underrun_i(tx_underrun_i), .tx_half_i(tx_half_i),
  .xfer_done_i(xfer_done_i), .stat_q(stat_q), .en_q(en_q), .gie_q(gie_q), .irq_o(irq_o)
);

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rx_nonempty_i = 0, rx_full_i = 0, rx_overrun_i = 0;
  logic tx_underrun_i = 0, tx_half_i = 0, xfer_done_i = 0;
  logic irq_o;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  irq_agg u_dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 enable", v, 0);
    rd(2'd2, v); chk("R1 master", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_toggle;
    logic [31:0] v;
    wr(2'd0, 32'h0000_0168); rd(2'd0, v); chk("R3 set by toggle", v, 32'h168);
    wr(2'd0, 32'h0000_0048); rd(2'd0, v); chk("R3 partial toggle", v, 32'h120);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R10 unused bits", v, 32'h05C);
    wr(2'd0, 32'h0000_005C); rd(2'd0, v); chk("R3 clear", v, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); rx_full_i = 1;
    @(negedge clk); rd(2'd0, v); chk("R4 full sets bit4", v, 32'h010);
    wr(2'd0, 32'h10); rd(2'd0, v); chk("R4 full re-sets", v, 32'h010);
    rx_full_i = 0; rx_nonempty_i = 1;
    wr(2'd0, 32'h10); rd(2'd0, v); chk("R4 rx data bit8", v, 32'h100);
    wr(2'd0, 32'h100); rd(2'd0, v); chk("R4 bit8 re-sets", v, 32'h100);
    rx_nonempty_i = 0;
    wr(2'd0, 32'h100); rd(2'd0, v); chk("R4 clear after drop", v, 0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    @(negedge clk); xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0; rd(2'd0, v); chk("R5 xfer done", v, 32'h104);
    wr(2'd0, 32'h104);
    @(negedge clk); rx_overrun_i = 1;
    @(negedge clk); rx_overrun_i = 0; rd(2'd0, v); chk("R6 overrun", v, 32'h020);
    @(negedge clk); tx_underrun_i = 1;
    @(negedge clk); tx_underrun_i = 0; rd(2'd0, v); chk("R6 underrun", v, 32'h028);
    @(negedge clk); tx_half_i = 1;
    @(negedge clk); tx_half_i = 0; rd(2'd0, v); chk("R6 half empty", v, 32'h068);
    wr(2'd0, 32'h068); rd(2'd0, v); chk("R2 cleared map", v, 0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    @(negedge clk); rx_overrun_i = 1;
    @(negedge clk); rx_overrun_i = 0;
    @(negedge clk); reg_addr = 2'd0; reg_wdata = 32'h20; reg_wr = 1; rx_overrun_i = 1;
    @(negedge clk); reg_wr = 0; rx_overrun_i = 0;
    rd(2'd0, v); chk("R7 event wins", v, 32'h020);
    wr(2'd0, 32'h20);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R9 enable mask", v, 32'h17C);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R9 master bit31", v, 32'h8000_0000);
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R9 addr3 zero", v, 0);
    rd(2'd0, v); chk("R9 addr3 no effect", v, 0);
    wr(2'd1, 0); wr(2'd2, 0);
  endtask

  task automatic t_irq;
    wr(2'd1, 32'h100); wr(2'd2, 32'h8000_0000);
    chk("R8 idle low", {31'b0, irq_o}, 0);
    @(negedge clk); xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0;
    chk("R8 one clock late", {31'b0, irq_o}, 0);
    @(negedge clk); chk("R8 raised", {31'b0, irq_o}, 1);
    wr(2'd2, 0);
    chk("R8 master off lag", {31'b0, irq_o}, 1);
    @(negedge clk); chk("R8 master off", {31'b0, irq_o}, 0);
    wr(2'd2, 32'h8000_0000);
    @(negedge clk); chk("R8 master back", {31'b0, irq_o}, 1);
    wr(2'd0, 32'h104);
    @(negedge clk); chk("R8 cleared low", {31'b0, irq_o}, 0);
    wr(2'd1, 32'h004); @(negedge clk); xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0; wr(2'd1, 32'h010);
    @(negedge clk); chk("R8 masked source", {31'b0, irq_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_toggle; t_level; t_events; t_collision; t_regs; t_irq;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule